// File: doc/BRIEF.md
# Serial Clock Synthesizer Word Loader

This block loads a 24-bit control word into an external frequency synthesizer over two wires, a serial clock and a serial data line. Both wires are single bits of an 8-bit shared output control register; the block owns those two bits only while it is loading and carries every other bit through unchanged. Software or a sequencer places the word and the current register value on the inputs and pulses start. The block captures both, then walks a fixed step list: an unlock preamble, a start pattern, the 24 payload bits least significant bit first, and a stop pattern. Each step holds its pin levels for a set number of system clocks.

Each payload bit takes four steps. The complement of the bit is shown with the serial clock high and then low. The true value is then shown with the clock low and then high, so the synthesizer latches the bit on the final rising edge. The block does not decode the word. The word packs several fields from the low bits upward: the reference divider less two in 7 bits, a 3-bit post-divider exponent, the feedback divider less three in 7 bits, a 4-bit oscillator band index, and a 3-bit select for the target clock register. After the stop pattern the block restores the captured register value and waits a settle period, about 0.1 s in the target system. It then pulses done.

Top module: `synth_word_loader`

## Requirements
- R1: During and right after reset, busy_o and done_o are 0 and reg_o equals reg_i.
- R2: While busy_o is 0, reg_o follows reg_i in the same cycle.
- R3: A start_i pulse sampled while idle captures word_i and reg_i, and busy_o is 1 in the next cycle.
- R4: The first 12 steps drive (data,clk) as (1,0),(1,1) repeated six times. Data is reg_o bit 3 and clk is reg_o bit 2.
- R5: The next 5 steps drive (1,0),(0,0),(0,1),(0,0),(0,1).
- R6: The next 96 steps send the captured word least significant bit first, four steps per bit b: (~b,1),(~b,0),(b,0),(b,1). The data level at each rising clk edge in this phase rebuilds the word.
- R7: The last 3 steps drive (1,1),(1,0),(1,1). After them reg_o equals the captured register value.
- R8: While busy_o is 1, every reg_o bit other than bits 2 and 3 equals the captured register value, whatever reg_i does.
- R9: Each step holds its levels for exactly STEP_CYCLES clocks (at least 2).
- R10: After the stop pattern, busy_o stays 1 for SETTLE_CYCLES clocks. Then done_o is 1 for one cycle while busy_o is 0.
- R11: A start_i pulse while busy_o is 1 is ignored. The word in flight is not changed and no second load follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request pulse |
| word_i | input | 24 | Control word to send |
| reg_i | input | 8 | Current value of the shared control register |
| reg_o | output | 8 | Value to write to the shared control register |
| busy_o | output | 1 | Load or settle in progress |
| done_o | output | 1 | One-cycle pulse when the load has settled |

## Verification
The bench builds the block with STEP_CYCLES=3 and SETTLE_CYCLES=20. With a three-clock step, a step that ends one clock early or late shows up as a mismatch at the first or last sample of that step. The short settle lets about two dozen complete loads fit in the run, covering all-zero, all-one, alternating and single-set-bit words as well as random ones. In each load the bench scrambles reg_i and sends a stray start pulse midway, so capture of the register value and rejection of a start during a load are both tested.

// File: rtl/synth_loader_pkg.sv
`timescale 1ns/1ps
package synth_loader_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_SETTLE} ld_state_e;

  typedef struct packed {
    logic sdat;
    logic sclk;
  } pin_pair_t;

  localparam int PRE_STEPS     = 12;
  localparam int SYNC_STEPS    = 5;
  localparam int STEPS_PER_BIT = 4;
  localparam int STOP_STEPS    = 3;
endpackage

// File: rtl/sl_hold_counter.sv
`timescale 1ns/1ps
module sl_hold_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sl_pattern_gen.sv
`timescale 1ns/1ps
module sl_pattern_gen
  import synth_loader_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SW     = 7
) (
  input  logic [SW-1:0]     step_i,
  input  logic [WORD_W-1:0] word_i,
  output pin_pair_t         pins_o
);
  localparam int DATA_BASE = PRE_STEPS + SYNC_STEPS;
  localparam int DATA_END  = DATA_BASE + STEPS_PER_BIT * WORD_W;
  localparam int BW        = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  int            s;
  int            j;
  logic          b;
  logic [1:0]    sub;
  logic [BW-1:0] bidx;

  always_comb begin
    s      = int'(step_i);
    j      = 0;
    sub    = 2'd0;
    bidx   = '0;
    b      = 1'b0;
    pins_o = '{sdat: 1'b1, sclk: 1'b1};
    if (s < PRE_STEPS) begin
      pins_o = '{sdat: 1'b1, sclk: step_i[0]};
    end else if (s < DATA_BASE) begin
      case (s - PRE_STEPS)
        0:       pins_o = '{sdat: 1'b1, sclk: 1'b0};
        1, 3:    pins_o = '{sdat: 1'b0, sclk: 1'b0};
        default: pins_o = '{sdat: 1'b0, sclk: 1'b1};
      endcase
    end else if (s < DATA_END) begin
      j    = s - DATA_BASE;
      bidx = BW'(j / STEPS_PER_BIT);
      sub  = 2'(j % STEPS_PER_BIT);
      b    = word_i[bidx];
      // complement first, true value latched on the final rising clock
      case (sub)
        2'd0:    pins_o = '{sdat: ~b, sclk: 1'b1};
        2'd1:    pins_o = '{sdat: ~b, sclk: 1'b0};
        2'd2:    pins_o = '{sdat:  b, sclk: 1'b0};
        default: pins_o = '{sdat:  b, sclk: 1'b1};
      endcase
    end else begin
      pins_o = '{sdat: 1'b1, sclk: (s - DATA_END) != 1};
    end
  end
endmodule

// File: rtl/synth_word_loader.sv
`timescale 1ns/1ps
module synth_word_loader
  import synth_loader_pkg::*;
#(
  parameter int WORD_W        = 24,
  parameter int REG_W         = 8,
  parameter int CLK_BIT       = 2,
  parameter int DAT_BIT       = 3,
  parameter int STEP_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 5_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int TOTAL_STEPS = PRE_STEPS + SYNC_STEPS + STEPS_PER_BIT * WORD_W + STOP_STEPS;
  localparam int SW          = $clog2(TOTAL_STEPS);

  ld_state_e         state_q;
  logic [SW-1:0]     step_q;
  logic [WORD_W-1:0] word_q;
  logic [REG_W-1:0]  reg_q;
  logic              done_q;
  logic              step_last;
  logic              settle_last;
  pin_pair_t         pins;
  logic [REG_W-1:0]  drive_reg;

  sl_hold_counter #(.LIMIT(STEP_CYCLES)) u_step_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SHIFT),
    .last_o (step_last)
  );

  sl_hold_counter #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_SETTLE),
    .last_o (settle_last)
  );

  sl_pattern_gen #(.WORD_W(WORD_W), .SW(SW)) u_pattern (
    .step_i (step_q),
    .word_i (word_q),
    .pins_o (pins)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      word_q  <= '0;
      reg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_SETTLE) && settle_last;
      case (state_q)
        ST_IDLE: if (start_i) begin
          word_q  <= word_i;
          reg_q   <= reg_i;
          step_q  <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (step_last) begin
          if (step_q == SW'(TOTAL_STEPS - 1)) state_q <= ST_SETTLE;
          else                                step_q  <= step_q + 1'b1;
        end
        ST_SETTLE: if (settle_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (g == CLK_BIT) begin : g_clk
      assign drive_reg[g] = pins.sclk;
    end else if (g == DAT_BIT) begin : g_dat
      assign drive_reg[g] = pins.sdat;
    end else begin : g_keep
      assign drive_reg[g] = reg_q[g];
    end
  end

  always_comb begin
    case (state_q)
      ST_SHIFT:  reg_o = drive_reg;
      ST_SETTLE: reg_o = reg_q;
      default:   reg_o = reg_i;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/synth_word_loader_chk.sv
`timescale 1ns/1ps
module synth_word_loader_chk #(
  parameter int REG_W   = 8,
  parameter int CLK_BIT = 2,
  parameter int DAT_BIT = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [REG_W-1:0] reg_i,
  input logic [REG_W-1:0] reg_o,
  input logic             busy_o,
  input logic             done_o
);
  localparam logic [REG_W-1:0] KEEP_MASK =
    ~((REG_W'(1) << CLK_BIT) | (REG_W'(1) << DAT_BIT));

  p_idle_passthru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> reg_o == reg_i);

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_keep_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((reg_o & KEEP_MASK) == ($past(reg_o) & KEEP_MASK)));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_on_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

bind synth_word_loader synth_word_loader_chk #(
  .REG_W(REG_W), .CLK_BIT(CLK_BIT), .DAT_BIT(DAT_BIT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .reg_i   (reg_i),
  .reg_o   (reg_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/synth_word_loader_bench.sv
`timescale 1ns/1ps
module synth_word_loader_bench;
  localparam int S      = 3;
  localparam int SC     = 20;
  localparam int NSTEPS = 116;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] word_i = '0;
  logic [7:0]  reg_i = '0;
  logic [7:0]  reg_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;

  synth_word_loader #(.STEP_CYCLES(S), .SETTLE_CYCLES(SC)) u_synth_word_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_i(word_i),
    .reg_i(reg_i), .reg_o(reg_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk_i = ~clk_i;

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {data,clk} for step k
  function automatic logic [1:0] exp_pins(int k, logic [23:0] w);
    int  n;
    logic v;
    if (k < 12) return (k % 2 == 0) ? 2'b10 : 2'b11;
    if (k < 17) begin
      case (k)
        12:      return 2'b10;
        14, 16:  return 2'b01;
        default: return 2'b00;
      endcase
    end
    if (k < 113) begin
      n = (k - 17) / 4;
      v = w[n];
      case ((k - 17) % 4)
        0:       return {~v, 1'b1};
        1:       return {~v, 1'b0};
        2:       return {v, 1'b0};
        default: return {v, 1'b1};
      endcase
    end
    return (k == 114) ? 2'b10 : 2'b11;
  endfunction

  function automatic string phase_tag(int k);
    if (k < 12)  return "R4";
    if (k < 17)  return "R5";
    if (k < 113) return "R6";
    return "R7";
  endfunction

  task automatic run_load(input logic [23:0] w, input logic [7:0] rv);
    logic [7:0]  exp_reg;
    logic [1:0]  p;
    logic [7:0]  exp_full;
    logic [23:0] got;
    logic        prev_clk;
    logic        dat [NSTEPS];
    bit          ok_pins, ok_keep, ok_c;
    int          nbits;
    logic [7:0]  bad_val, bad_exp;
    @(negedge clk_i);
    start_i = 1'b1; word_i = w; reg_i = rv; exp_reg = rv;
    @(negedge clk_i);
    start_i = 1'b0;
    word_i  = ~w;
    chk(busy_o == 1'b1, "R3 busy after start", 32'(busy_o), 32'd1);
    got = '0; nbits = 0; prev_clk = 1'b1;
    for (int k = 0; k < NSTEPS; k++) begin
      p = exp_pins(k, w);
      exp_full = {exp_reg[7:4], p[1], p[0], exp_reg[1:0]};
      ok_pins = 1'b1; ok_keep = 1'b1; bad_val = '0; bad_exp = '0;
      for (int c = 0; c < S; c++) begin
        if (reg_o[3:2] != p) begin ok_pins = 1'b0; bad_val = reg_o; bad_exp = exp_full; end
        if ({reg_o[7:4], reg_o[1:0]} != {exp_reg[7:4], exp_reg[1:0]}) begin
          ok_keep = 1'b0; bad_val = reg_o; bad_exp = exp_full;
        end
        if (c == 0) dat[k] = reg_o[3];
        if (k >= 17 && k < 113 && reg_o[2] && !prev_clk) begin
          got = {reg_o[3], got[23:1]};
          nbits++;
        end
        prev_clk = reg_o[2];
        reg_i   = 8'($urandom);
        start_i = (k == 60 && c == 0);  // R11: stray start mid-load
        if (k == 60 && c == 0) word_i = ~w;
        @(negedge clk_i);
      end
      start_i = 1'b0;
      chk(ok_pins, $sformatf("%s (R9 hold) step %0d", phase_tag(k), k), 32'(bad_val), 32'(bad_exp));
      chk(ok_keep, $sformatf("R8 other bits step %0d", k), 32'(bad_val), 32'(bad_exp));
    end
    chk(got == w && nbits == 24, "R6 recovered payload (R11)", 32'(got), 32'(w));
    ok_c = 1'b1;
    for (int i = 0; i < 24; i++)
      if (dat[17 + 4*i] != ~dat[20 + 4*i] || dat[18 + 4*i] != ~dat[20 + 4*i]) ok_c = 1'b0;
    chk(ok_c, "R6 complement precedes true bit", 32'(ok_c), 32'd1);
    for (int c = 0; c < SC; c++) begin
      chk(reg_o == exp_reg && busy_o && !done_o, "R7 R10 settle restore",
          {22'd0, busy_o, done_o, reg_o}, {22'd0, 1'b1, 1'b0, exp_reg});
      reg_i = 8'($urandom);
      @(negedge clk_i);
    end
    chk(done_o && !busy_o, "R10 done pulse", {30'd0, busy_o, done_o}, 32'd1);
    @(negedge clk_i);
    chk(!done_o, "R10 done single cycle", 32'(done_o), 32'd0);
    for (int c = 0; c < 4; c++) begin
      chk(!busy_o, "R11 no second load", 32'(busy_o), 32'd0);
      @(negedge clk_i);
    end
  endtask

  initial begin
    logic [23:0] dir_words [6];
    void'($urandom(32'h5eed_2061));
    dir_words = '{24'h000000, 24'hFFFFFF, 24'hAAAAAA, 24'h555555, 24'h000001, 24'h800000};
    reg_i = 8'hA5;
    #35;
    chk(!busy_o && !done_o && reg_o == reg_i, "R1 reset state",
        {22'd0, busy_o, done_o, reg_o}, {24'd0, reg_i});
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && reg_o == 8'hA5, "R1 after reset",
        {22'd0, busy_o, done_o, reg_o}, 32'hA5);
    for (int i = 0; i < 5; i++) begin
      reg_i = 8'($urandom);
      #1;
      chk(reg_o == reg_i, "R2 idle passthrough", 32'(reg_o), 32'(reg_i));
      @(negedge clk_i);
    end
    foreach (dir_words[i]) run_load(dir_words[i], (i % 2 == 0) ? 8'hF3 : 8'h00);
    for (int i = 0; i < 18; i++) run_load(24'($urandom), 8'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule